// File: doc/BRIEF.md
# MAC and PHY reset sequencer

This block gathers every reset source of a combined Ethernet MAC and PHY and turns them into two independent reset domains. The MAC side is reset by a qualified external reset pin or by a level-held software reset bit. The PHY side is reset by a power-on indication, a write of its self-clearing management reset bit, a falling software reset bit or the external pin. The block also produces a one-cycle request to latch the PHY management address, a one-cycle request to start a serial EEPROM configuration load, a PHY-ready flag and the readback value of the PHY management reset bit.

The external pin goes through a synchronizer and must stay high for a minimum time, counted in clock cycles, before it takes effect. Shorter pulses have no effect. Each PHY reset event starts an internal reset pulse of fixed length and a long ready interval, 50 ms by default. A simulation override can shorten that interval. A new event restarts the interval.

Top module: `macphy_rst_seq`

## Requirements
- R1: The pin acts only after it has been synchronized and has stayed high for QUAL_CYC consecutive cycles (13 at 125 MHz for 100 ns). A pulse shorter than that changes no output.
- R2: `mac_rst_o` is high from the cycle after `sw_rst_i` is sampled high and stays high until the cycle after it is sampled low. A rising `sw_rst_i` does not reset the PHY.
- R3: A qualified pin asserts `mac_rst_o` one cycle after qualification, until one cycle after the qualified level ends. After block reset every output is 0. A power-on event and a PHY bit write leave `mac_rst_o` at 0.
- R4: When the qualified pin level ends, `ee_load_o` pulses high for exactly one cycle if `ee_present_i` is 1. It stays 0 if `ee_present_i` is 0, and no other source produces it.
- R5: A rising `por_i`, a `phy_rst_wr_i` strobe or a falling `sw_rst_i` sampled at edge e drives `phy_rst_o` high from edge e for exactly PULSE_CYC cycles.
- R6: A qualified pin holds `phy_rst_o` high for as long as it lasts, and then for PULSE_CYC more cycles.
- R7: `phy_rst_rdbk_o` reads 1 from the edge that samples `phy_rst_wr_i` until the PHY pulse ends, and 0 for every other source.
- R8: `phy_addr_latch_o` pulses high for one cycle, in the first cycle after each PHY reset pulse ends.
- R9: `phy_ready_o` rises READY_CYC cycles after the edge that starts a PHY reset, or after the edge where the pin's effect ends, and is low before that.
- R10: A new PHY reset event while the ready interval runs drops `phy_ready_o` and restarts the full interval from that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| rst_pin_i | input | 1 | External reset pin, asynchronous, active high |
| por_i | input | 1 | Power-applied indication, rising edge is the event |
| sw_rst_i | input | 1 | Software reset bit, level held |
| phy_rst_wr_i | input | 1 | One-cycle strobe: 1 written to the PHY management reset bit |
| ee_present_i | input | 1 | Serial EEPROM detected and enabled |
| mac_rst_o | output | 1 | MAC register reset |
| phy_rst_o | output | 1 | PHY core reset |
| phy_addr_latch_o | output | 1 | One-cycle request to latch the PHY management address |
| ee_load_o | output | 1 | One-cycle request to load configuration from EEPROM |
| phy_ready_o | output | 1 | PHY ready for access |
| phy_rst_rdbk_o | output | 1 | Readback of the PHY management reset bit |

## Verification
Suppose a qualification counter is stuck or its threshold is off by one. Then the test pulse one cycle short of the threshold asserts `mac_rst_o`, or the long pulse asserts it one cycle early or late, and both show up at the exact cycle. A pulse counter or pending flag that is out of step moves the falling edges of `phy_rst_o` and `phy_rst_rdbk_o`, and the `phy_addr_latch_o` strobe, within PULSE_CYC cycles of the event. A ready timer that fails to reload shows `phy_ready_o` rising at the earlier time during the restart test.

// File: rtl/macphy_rst_pkg.sv
package macphy_rst_pkg;

  // Round a nanosecond interval up to whole clock cycles.
  function automatic longint ns_to_cyc(longint hz, longint ns);
    return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

  // Millisecond interval in clock cycles.
  function automatic longint ms_to_cyc(longint hz, longint ms);
    return (hz / 64'd1000) * ms;
  endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_act_o,
  output logic pin_fall_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [QW-1:0]          cnt_q, cnt_d;
  logic                   act_prev_q;

  // synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!pin_s)             cnt_d = '0;
    else if (cnt_q == QMAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_prev_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      act_prev_q <= pin_act_o;
    end
  end

  assign pin_act_o  = (cnt_q == QMAX);
  assign pin_fall_o = act_prev_q & ~pin_act_o;

  // R1
  pin_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_act_o) |-> $past(pin_s));

endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hold_i,
  input  logic set_pend_i,
  output logic rst_o,
  output logic pend_o,
  output logic latch_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_CYC);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pend_q, pend_d;
  logic          latch_q, latch_d;
  logic          load, done;

  assign load = start_i | hold_i;
  assign done = (pcnt_q == PW'(1)) & ~load;

  always_comb begin
    if (load)              pcnt_d = PLEN;
    else if (pcnt_q != '0) pcnt_d = pcnt_q - 1'b1;
    else                   pcnt_d = pcnt_q;
    pend_d  = set_pend_i | (pend_q & ~done);
    latch_d = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      pcnt_q  <= pcnt_d;
      pend_q  <= pend_d;
      latch_q <= latch_d;
    end
  end

  assign rst_o   = (pcnt_q != '0);
  assign pend_o  = pend_q;
  assign latch_o = latch_q;

  // R7
  pend_inside_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o |-> rst_o);
  // R8
  latch_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> $fell(rst_o));

endmodule

// File: rtl/rst_ready_timer.sv
module rst_ready_timer #(
  parameter int READY_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hold_i,
  output logic ready_o
);
  localparam int TW = $clog2(READY_CYC + 1);
  localparam logic [TW-1:0] TLEN = TW'(READY_CYC);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          rdy_q, rdy_d;
  logic          load;

  assign load = start_i | hold_i;

  always_comb begin
    if (load)              tcnt_d = TLEN;
    else if (tcnt_q != '0) tcnt_d = tcnt_q - 1'b1;
    else                   tcnt_d = tcnt_q;
    rdy_d = ~load & (rdy_q | (tcnt_q == TW'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ready_o = rdy_q;

  // R10
  restart_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ready_o);

endmodule

// File: rtl/macphy_rst_seq.sv
module macphy_rst_seq #(
  parameter int CLK_HZ        = 125_000_000,
  parameter int PIN_MIN_NS    = 100,
  parameter int READY_MS      = 50,
  parameter int SIM_READY_CYC = 0,
  parameter int PULSE_CYC     = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_i,
  input  logic por_i,
  input  logic sw_rst_i,
  input  logic phy_rst_wr_i,
  input  logic ee_present_i,
  output logic mac_rst_o,
  output logic phy_rst_o,
  output logic phy_addr_latch_o,
  output logic ee_load_o,
  output logic phy_ready_o,
  output logic phy_rst_rdbk_o
);
  import macphy_rst_pkg::*;

  localparam int QUAL_CYC  = int'(ns_to_cyc(longint'(CLK_HZ), longint'(PIN_MIN_NS)));
  localparam int READY_CYC = (SIM_READY_CYC > 0) ? SIM_READY_CYC
                           : int'(ms_to_cyc(longint'(CLK_HZ), longint'(READY_MS)));

  logic pin_act, pin_fall;
  logic por_q, sw_q;
  logic por_rise, sw_fall, phy_start;
  logic mac_q, mac_d;
  logic ee_q, ee_d;

  rst_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_i(rst_pin_i),
    .pin_act_o(pin_act), .pin_fall_o(pin_fall)
  );

  assign por_rise  = por_i & ~por_q;
  assign sw_fall   = sw_q & ~sw_rst_i;
  assign phy_start = por_rise | phy_rst_wr_i | sw_fall | pin_fall;

  always_comb begin
    mac_d = pin_act | sw_rst_i;
    ee_d  = pin_fall & ee_present_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b0;
      sw_q  <= 1'b0;
      mac_q <= 1'b0;
      ee_q  <= 1'b0;
    end else begin
      por_q <= por_i;
      sw_q  <= sw_rst_i;
      mac_q <= mac_d;
      ee_q  <= ee_d;
    end
  end

  rst_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start_i(phy_start), .hold_i(pin_act),
    .set_pend_i(phy_rst_wr_i), .rst_o(phy_rst_o), .pend_o(phy_rst_rdbk_o),
    .latch_o(phy_addr_latch_o)
  );

  rst_ready_timer #(.READY_CYC(READY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(phy_start), .hold_i(pin_act),
    .ready_o(phy_ready_o)
  );

  assign mac_rst_o = mac_q;
  assign ee_load_o = ee_q;

  // R2
  sw_holds_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> mac_rst_o);
  // R4
  ee_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_load_o |=> !ee_load_o);
  // R9
  not_ready_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst_o |-> !phy_ready_o);

endmodule

// File: tb/sim_macphy_rst_seq.sv
`timescale 1ns/1ps
module sim_macphy_rst_seq;
  localparam int P = 16;
  localparam int R = 100;
  localparam int Q = 13;

  typedef enum int {S_MAC, S_PHY, S_LATCH, S_EE, S_RDY, S_RDBK} sig_e;
  typedef struct { int cyc; sig_e s; bit v; string req; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin_i = 1'b0, por_i = 1'b0, sw_rst_i = 1'b0;
  logic phy_rst_wr_i = 1'b0, ee_present_i = 1'b0;
  logic mac_rst_o, phy_rst_o, phy_addr_latch_o, ee_load_o, phy_ready_o, phy_rst_rdbk_o;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  macphy_rst_seq #(.SIM_READY_CYC(R), .PULSE_CYC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin_i), .por_i(por_i),
    .sw_rst_i(sw_rst_i), .phy_rst_wr_i(phy_rst_wr_i), .ee_present_i(ee_present_i),
    .mac_rst_o(mac_rst_o), .phy_rst_o(phy_rst_o), .phy_addr_latch_o(phy_addr_latch_o),
    .ee_load_o(ee_load_o), .phy_ready_o(phy_ready_o), .phy_rst_rdbk_o(phy_rst_rdbk_o)
  );

  function automatic logic pick(sig_e s);
    case (s)
      S_MAC:   return mac_rst_o;
      S_PHY:   return phy_rst_o;
      S_LATCH: return phy_addr_latch_o;
      S_EE:    return ee_load_o;
      S_RDY:   return phy_ready_o;
      default: return phy_rst_rdbk_o;
    endcase
  endfunction

  task automatic push(int c, sig_e s, bit v, string r);
    item_t it;
    int i;
    it.cyc = c; it.s = s; it.v = v; it.req = r;
    i = q.size();
    while (i > 0 && q[i-1].cyc > c) i--;
    q.insert(i, it);
  endtask

  // monitor: compare expected items at their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic a;
      it = q.pop_front();
      a = pick(it.s);
      nchk++;
      if (it.cyc != cyc || a !== it.v) begin
        nerr++;
        $display("FAIL %s sig=%s cyc=%0d actual=%b expected=%b", it.req, it.s.name(), cyc, a, it.v);
      end
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic pin_pulse(int h);
    int c;
    @(negedge clk);
    c = cyc;
    rst_pin_i = 1'b1;
    repeat (h) @(negedge clk);
    rst_pin_i = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int c, e, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c = cyc;
    // R3 reset state
    push(c+1, S_MAC, 0, "R3"); push(c+1, S_PHY, 0, "R3");
    push(c+1, S_RDY, 0, "R3"); push(c+1, S_RDBK, 0, "R3");
    push(c+1, S_LATCH, 0, "R3"); push(c+1, S_EE, 0, "R3");
    drain();

    // PHY bit write: R5 R7 R8 R9
    @(negedge clk); c = cyc; e = c + 1;
    phy_rst_wr_i = 1'b1;
    push(e, S_PHY, 1, "R5"); push(e, S_RDBK, 1, "R7"); push(e, S_MAC, 0, "R3");
    push(e+P-1, S_PHY, 1, "R5"); push(e+P-1, S_RDBK, 1, "R7");
    push(e+P, S_PHY, 0, "R5"); push(e+P, S_RDBK, 0, "R7");
    push(e+P, S_LATCH, 1, "R8"); push(e+P+1, S_LATCH, 0, "R8");
    push(e+R-1, S_RDY, 0, "R9"); push(e+R, S_RDY, 1, "R9");
    @(negedge clk); phy_rst_wr_i = 1'b0;
    drain();

    // restart during the ready interval: R10
    @(negedge clk); c = cyc; e = c + 1;
    phy_rst_wr_i = 1'b1;
    @(negedge clk); phy_rst_wr_i = 1'b0;
    repeat (48) @(negedge clk);
    c = cyc; d = c + 1;
    phy_rst_wr_i = 1'b1;
    push(e+R, S_RDY, 0, "R10"); push(d+R-1, S_RDY, 0, "R10"); push(d+R, S_RDY, 1, "R10");
    @(negedge clk); phy_rst_wr_i = 1'b0;
    drain();

    // power-on event: R5 R7 R3
    @(negedge clk); c = cyc; e = c + 1;
    por_i = 1'b1;
    push(e, S_PHY, 1, "R5"); push(e, S_RDBK, 0, "R7"); push(e+5, S_MAC, 0, "R3");
    push(e+P, S_LATCH, 1, "R8"); push(e+R, S_RDY, 1, "R9");
    @(negedge clk); por_i = 1'b0;
    drain();

    // software reset level: R2 R5
    @(negedge clk); c = cyc;
    sw_rst_i = 1'b1;
    push(c+1, S_MAC, 1, "R2"); push(c+1, S_PHY, 0, "R2");
    push(c+5, S_RDY, 1, "R2"); push(c+40, S_MAC, 1, "R2");
    repeat (50) @(negedge clk);
    d = cyc;
    sw_rst_i = 1'b0;
    push(d+1, S_MAC, 0, "R2"); push(d+1, S_PHY, 1, "R5"); push(d+1, S_RDY, 0, "R9");
    push(d+1, S_RDBK, 0, "R7"); push(d+P, S_PHY, 1, "R5"); push(d+1+P, S_PHY, 0, "R5");
    push(d+1+P, S_LATCH, 1, "R8"); push(d+1+R, S_RDY, 1, "R9");
    drain();

    // short pin pulse, one cycle below threshold: R1
    ee_present_i = 1'b1;
    @(negedge clk); c = cyc;
    for (int k = 1; k <= 40; k += 3) begin
      push(c+k, S_MAC, 0, "R1"); push(c+k, S_PHY, 0, "R1");
      push(c+k, S_EE, 0, "R1"); push(c+k, S_RDY, 1, "R1");
    end
    rst_pin_i = 1'b1;
    repeat (Q-1) @(negedge clk);
    rst_pin_i = 1'b0;
    drain();

    // long pin pulse with EEPROM: R1 R3 R4 R6 R9
    @(negedge clk); c = cyc;
    push(c+2+Q, S_MAC, 0, "R1"); push(c+3+Q, S_MAC, 1, "R1");
    push(c+3+Q, S_PHY, 1, "R6"); push(c+3+Q, S_RDY, 0, "R9");
    push(c+30+3, S_MAC, 1, "R3"); push(c+30+4, S_MAC, 0, "R3");
    push(c+30+3, S_EE, 0, "R4"); push(c+30+4, S_EE, 1, "R4"); push(c+30+5, S_EE, 0, "R4");
    push(c+30+3+P, S_PHY, 1, "R6"); push(c+30+4+P, S_PHY, 0, "R6");
    push(c+30+4+P, S_LATCH, 1, "R8"); push(c+30+4+P, S_RDBK, 0, "R7");
    push(c+30+3+R, S_RDY, 0, "R9"); push(c+30+4+R, S_RDY, 1, "R9");
    rst_pin_i = 1'b1;
    repeat (30) @(negedge clk);
    rst_pin_i = 1'b0;
    drain();

    // long pin pulse without EEPROM: R4
    ee_present_i = 1'b0;
    @(negedge clk); c = cyc;
    push(c+30+4, S_EE, 0, "R4"); push(c+30+4, S_MAC, 0, "R3"); push(c+30+3, S_MAC, 1, "R3");
    rst_pin_i = 1'b1;
    repeat (30) @(negedge clk);
    rst_pin_i = 1'b0;
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule